// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer on a simple word-addressed register bus. A 16-bit divider turns the bus clock into ticks, and each tick counts down a reloadable timeout counter. When the counter reaches zero, the block raises a reset request for one clock. It then holds at zero until software reloads it or switches the watchdog off.

Each of the four controls is guarded by its own lock word. The controls are reload (kick), timeout length (change), on/off (disable) and tick divider (prescale). Software has to write a fixed series of key values into a lock word before the data word next to it will take a write. Any key out of order sends that lock back to the start. Every accepted data write locks it again. The lock progress can be read back in the two low bits of the lock word, so software can confirm each step before it writes the data word.

Top module: `keyed_wdt`

## Requirements
- R1: Word index 0..7 selects, in order: kick lock, kick, change lock, change, disable lock, disable, prescale lock, prescale. A lock word reads its status in bits 1:0 with upper bits zero. Change and prescale read their 16-bit value, disable reads the enable flag in bit 0, and kick reads zero. Read data is registered and appears one cycle after the index is applied.
- R2: After reset the watchdog is off, all four locks read 0, change and prescale both read 0xFFFF, and the reset output is low.
- R3: Kick lock: writing 0x5555 gives status 1, then writing 0xAAAA gives status 3.
- R4: Change lock: 0x6666 gives status 1, then 0xBBBB gives status 3. Prescale lock: 0x5A5A gives status 1, then 0xA5A5 gives status 3.
- R5: Disable lock needs three keys: 0x7777 gives status 1, 0xCCCC gives status 2, and 0xDDDD gives status 3.
- R6: A lock write that is neither the first key nor the next expected key returns that lock to status 0. The first key always sets status 1.
- R7: A data write at status 3 is accepted and returns the lock to 0. A data write below status 3 is ignored, and the lock status is left unchanged.
- R8: An accepted disable-word write loads bit 0 as the enable flag: 1 runs the watchdog, 0 stops it. Enabling does not reload the counter.
- R9: An accepted kick write of exactly 1 reloads the counter from the change value and restarts the divider. Any other accepted kick value reloads nothing.
- R10: After a reload with change C and prescale P (P of 0 acts as 1), the reset output is high for exactly one cycle, C*P cycles after the reload edge. The counter then stays at zero and produces no further pulse until the next reload.
- R11: An accepted change write of 0 stores 1. A new change value does not alter a count in progress; it applies at the next reload.
- R12: While disabled, the count is frozen and no reset pulse appears. Re-enabling resumes from the frozen count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, also the divider input |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 3 | Word index in the register map |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data of the addressed word |
| wdt_rst | output | 1 | One-cycle reset request on expiry |

## Verification
The bench sweeps prescale 1..4 against change 1..5 and compares each expiry time with the product C*P. An off-by-one in the divider or the counter shows up there as a timeout that is a cycle or one tick short or long. It walks every lock through its full key series and through out-of-order keys. A design that skipped a disable step, or failed to relock after a data write, would show the wrong status or accept a locked write. It also checks the cases where a result must stay unchanged: a change written mid-count, a non-1 kick, re-enabling after expiry, and a pause while disabled. A design that reloaded too eagerly or kept counting while off would fire a pulse at the wrong time or not at all.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int NCTRL  = 4;
  localparam int KEY_W  = 16;
  localparam int AW     = 3;
  localparam int MAXKEY = 3;

  // control order follows the address map: kick, change, disable, prescale
  localparam int C_KICK = 0;
  localparam int C_CHG  = 1;
  localparam int C_DIS  = 2;
  localparam int C_PSC  = 3;

  function automatic int ctl_nkeys(input int c);
    return (c == C_DIS) ? 3 : 2;
  endfunction

  // keys packed with the first key in the least significant slot
  function automatic logic [MAXKEY*KEY_W-1:0] ctl_keys(input int c);
    case (c)
      C_KICK:  return {16'h0000, 16'hAAAA, 16'h5555};
      C_CHG:   return {16'h0000, 16'hBBBB, 16'h6666};
      C_DIS:   return {16'hDDDD, 16'hCCCC, 16'h7777};
      default: return {16'h0000, 16'hA5A5, 16'h5A5A};
    endcase
  endfunction
endpackage

// File: rtl/kwdt_unlock.sv
module kwdt_unlock #(
  parameter int DW    = 32,
  parameter int KEY_W = 16,
  parameter int NKEYS = 2,
  parameter logic [NKEYS*KEY_W-1:0] KEYS = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lock_we,
  input  logic          data_we,
  input  logic [DW-1:0] wdata,
  output logic [1:0]    status,
  output logic          open_o
);
  localparam int SW = $clog2(NKEYS + 1);

  logic [SW-1:0]    step;
  logic [KEY_W-1:0] exp_key;
  logic             is_first, is_next;

  always_comb begin
    exp_key = '0;
    for (int k = 0; k < NKEYS; k++)
      if (SW'(k) == step) exp_key = KEYS[k*KEY_W +: KEY_W];
  end

  assign is_first = (wdata == DW'(KEYS[KEY_W-1:0]));
  assign is_next  = (step < SW'(NKEYS)) && (wdata == DW'(exp_key));
  assign open_o   = (step == SW'(NKEYS));
  assign status   = open_o ? 2'd3 : 2'(step);

  always_ff @(posedge clk) begin
    if (rst)
      step <= '0;
    else if (lock_we) begin
      if (is_first)     step <= SW'(1);
      else if (is_next) step <= step + SW'(1);
      else              step <= '0;
    end else if (data_we && open_o)
      step <= '0;
  end

  p_relock_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (data_we && !lock_we && status == 2'd3) |=> (status == 2'd0));
  p_locked_write_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (data_we && !lock_we && status != 2'd3) |=> $stable(status));
  p_first_key_restarts_r6: assert property (@(posedge clk) disable iff (rst)
    (lock_we && wdata == DW'(KEYS[KEY_W-1:0])) |=> (status == 2'd1));
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          restart,
  input  logic [PW-1:0] div,
  output logic          tick
);
  logic [PW-1:0] pcnt;
  logic          last;

  assign last = (div <= PW'(1)) || (pcnt >= div - PW'(1));
  assign tick = run && last;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) pcnt <= '0;
    else if (last)              pcnt <= '0;
    else                        pcnt <= pcnt + PW'(1);
  end

  p_restart_clears_r9: assert property (@(posedge clk) disable iff (rst)
    restart |=> (pcnt == '0));
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic          reload,
  input  logic [CW-1:0] load_val,
  output logic          pulse
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '1;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (reload)
        cnt <= load_val;
      else if (en && tick && cnt != '0) begin
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) pulse <= 1'b1;
      end
    end
  end

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
  p_hold_at_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !reload) |=> (cnt == '0 && !pulse));
  p_frozen_when_off_r12: assert property (@(posedge clk) disable iff (rst)
    (!en && !reload) |=> $stable(cnt));
  p_quiet_when_off_r12: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pulse);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int DW = 32,
  parameter int VW = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [kwdt_pkg::AW-1:0] addr,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  output logic                   wdt_rst
);
  import kwdt_pkg::*;

  logic [1:0]       lk_stat [NCTRL];
  logic [NCTRL-1:0] lk_open, lock_we, data_we;
  logic [VW-1:0]    chg_q, psc_q;
  logic             en_q, kick_fire, tick;

  for (genvar g = 0; g < NCTRL; g++) begin : g_lock
    localparam int NK = ctl_nkeys(g);
    localparam logic [MAXKEY*KEY_W-1:0] KALL = ctl_keys(g);
    localparam logic [NK*KEY_W-1:0]     KSEL = KALL[NK*KEY_W-1:0];

    assign lock_we[g] = wr_en && (addr == AW'(2*g));
    assign data_we[g] = wr_en && (addr == AW'(2*g + 1));

    kwdt_unlock #(.DW(DW), .KEY_W(KEY_W), .NKEYS(NK), .KEYS(KSEL)) u_unlock (
      .clk     (clk),
      .rst     (rst),
      .lock_we (lock_we[g]),
      .data_we (data_we[g]),
      .wdata   (wdata),
      .status  (lk_stat[g]),
      .open_o  (lk_open[g])
    );
  end

  assign kick_fire = data_we[C_KICK] && lk_open[C_KICK] && (wdata == DW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_q <= '1;
      psc_q <= '1;
      en_q  <= 1'b0;
    end else begin
      if (data_we[C_CHG] && lk_open[C_CHG])
        chg_q <= (wdata[VW-1:0] == '0) ? VW'(1) : wdata[VW-1:0];
      if (data_we[C_PSC] && lk_open[C_PSC])
        psc_q <= wdata[VW-1:0];
      if (data_we[C_DIS] && lk_open[C_DIS])
        en_q <= wdata[0];
    end
  end

  kwdt_prescaler #(.PW(VW)) u_psc (
    .clk     (clk),
    .rst     (rst),
    .run     (en_q),
    .restart (kick_fire),
    .div     (psc_q),
    .tick    (tick)
  );

  kwdt_counter #(.CW(VW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .en       (en_q),
    .tick     (tick),
    .reload   (kick_fire),
    .load_val (chg_q),
    .pulse    (wdt_rst)
  );

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (!addr[0])
      rdata <= DW'(lk_stat[addr[2:1]]);
    else begin
      case (addr[2:1])
        2'd1:    rdata <= DW'(chg_q);
        2'd2:    rdata <= DW'(en_q);
        2'd3:    rdata <= DW'(psc_q);
        default: rdata <= '0;
      endcase
    end
  end

  p_change_never_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (data_we[C_CHG] && lk_open[C_CHG]) |=> (chg_q != '0));
endmodule

// File: tb/keyed_wdt_tb.sv
`timescale 1ns/1ps
module keyed_wdt_tb;
  logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wdt_rst;
  int checks = 0, fails = 0, cyc = 0;

  keyed_wdt u_dut (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
                   .wdata(wdata), .rdata(rdata), .wdt_rst(wdt_rst));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; addr = 3'(idx); wdata = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    @(negedge clk); addr = 3'(idx);
    @(negedge clk); v = rdata;
  endtask

  task automatic unlock_ctl(input int c);
    case (c)
      0: begin wr(0, 32'h5555); wr(0, 32'hAAAA); end
      1: begin wr(2, 32'h6666); wr(2, 32'hBBBB); end
      2: begin wr(4, 32'h7777); wr(4, 32'hCCCC); wr(4, 32'hDDDD); end
      default: begin wr(6, 32'h5A5A); wr(6, 32'hA5A5); end
    endcase
  endtask

  task automatic set_ctl(input int c, input logic [31:0] v);
    unlock_ctl(c); wr(2*c + 1, v);
  endtask

  task automatic wait_rst(input int t0, output int n);
    n = -1;
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk); @(negedge clk);
      if (wdt_rst) begin n = cyc - t0; break; end
    end
  endtask

  task automatic quiet(input int len, output logic seen);
    seen = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (wdt_rst) seen = 1'b1;
    end
  endtask

  initial begin
    logic [31:0] v;
    logic seen;
    int t0, n;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R2 reset state, R1 readback layout
    chk("R2 rst out", 32'(wdt_rst), 0);
    for (int c = 0; c < 4; c++) begin rd(2*c, v); chk("R2 lock", v, 0); end
    rd(3, v); chk("R2 change", v, 32'hFFFF);
    rd(7, v); chk("R2 prescale", v, 32'hFFFF);
    rd(5, v); chk("R2 enable", v, 0);
    rd(1, v); chk("R1 kick reads 0", v, 0);

    // R3, R4, R5 key progressions; R7 relock on accept
    wr(0, 32'h5555); rd(0, v); chk("R3 kick s1", v, 1);
    wr(0, 32'hAAAA); rd(0, v); chk("R3 kick s3", v, 3);
    wr(1, 32'h0);    rd(0, v); chk("R7 kick relock", v, 0);
    wr(2, 32'h6666); rd(2, v); chk("R4 chg s1", v, 1);
    wr(2, 32'hBBBB); rd(2, v); chk("R4 chg s3", v, 3);
    wr(3, 32'h8);    rd(3, v); chk("R7 chg accepted", v, 8);
    rd(2, v); chk("R7 chg relock", v, 0);
    wr(6, 32'h5A5A); rd(6, v); chk("R4 psc s1", v, 1);
    wr(6, 32'hA5A5); rd(6, v); chk("R4 psc s3", v, 3);
    wr(7, 32'h1);    rd(7, v); chk("R1 psc value", v, 1);
    wr(4, 32'h7777); rd(4, v); chk("R5 dis s1", v, 1);
    wr(4, 32'hCCCC); rd(4, v); chk("R5 dis s2", v, 2);
    wr(4, 32'hDDDD); rd(4, v); chk("R5 dis s3", v, 3);
    wr(5, 32'h0);    rd(4, v); chk("R7 dis relock", v, 0);

    // R6 out-of-order keys
    for (int c = 0; c < 4; c++) begin
      logic [31:0] k0, k1;
      k0 = (c == 0) ? 32'h5555 : (c == 1) ? 32'h6666 : (c == 2) ? 32'h7777 : 32'h5A5A;
      k1 = (c == 0) ? 32'hAAAA : (c == 1) ? 32'hBBBB : (c == 2) ? 32'hCCCC : 32'hA5A5;
      wr(2*c, k0); wr(2*c, 32'h1234); rd(2*c, v); chk("R6 bad key", v, 0);
      wr(2*c, k1); rd(2*c, v); chk("R6 second key first", v, 0);
      wr(2*c, k0); wr(2*c, k0); rd(2*c, v); chk("R6 first key again", v, 1);
      wr(2*c, 32'h0); rd(2*c, v); chk("R6 zero write", v, 0);
    end
    wr(4, 32'h7777); wr(4, 32'hDDDD); rd(4, v); chk("R6 dis skip step", v, 0);

    // R7 locked write ignored
    wr(2, 32'h6666); wr(3, 32'h55); rd(3, v); chk("R7 locked chg", v, 8);
    rd(2, v); chk("R7 lock unchanged", v, 1);
    wr(2, 32'h0);
    wr(5, 32'h1); rd(5, v); chk("R7 locked dis", v, 0);

    // R11 zero change clamps to 1
    set_ctl(1, 32'h0); rd(3, v); chk("R11 clamp", v, 1);

    // R8 enable readback
    set_ctl(2, 32'h1); rd(5, v); chk("R8 enabled", v, 1);

    // R10 sweep of prescale x change
    for (int p = 1; p <= 4; p++) begin
      for (int c = 1; c <= 5; c++) begin
        set_ctl(3, p); set_ctl(1, c);
        unlock_ctl(0); wr(1, 32'h1); t0 = cyc;
        wait_rst(t0, n);
        chk("R10 timeout", n, c*p);
        @(negedge clk); chk("R10 one cycle", 32'(wdt_rst), 0);
        quiet(3*c*p + 5, seen); chk("R10 stopped", 32'(seen), 0);
      end
    end

    // R10 prescale 0 acts as 1
    set_ctl(3, 32'h0); set_ctl(1, 32'h4);
    unlock_ctl(0); wr(1, 32'h1); t0 = cyc; wait_rst(t0, n);
    chk("R10 prescale zero", n, 4);

    // R9 non-1 kick does not reload
    unlock_ctl(0); wr(1, 32'h2); quiet(40, seen); chk("R9 kick value 2", 32'(seen), 0);

    // R9 mid-count kick restarts
    set_ctl(3, 32'h1); set_ctl(1, 32'd20);
    unlock_ctl(0); wr(1, 32'h1);
    repeat (5) @(negedge clk);
    unlock_ctl(0); wr(1, 32'h1); t0 = cyc; wait_rst(t0, n);
    chk("R9 restart", n, 20);

    // R11 change write during count has no effect until next kick
    set_ctl(3, 32'h2); set_ctl(1, 32'h8);
    unlock_ctl(0); wr(1, 32'h1); t0 = cyc;
    set_ctl(1, 32'd20);
    wait_rst(t0, n); chk("R11 running count kept", n, 16);
    unlock_ctl(0); wr(1, 32'h1); t0 = cyc; wait_rst(t0, n);
    chk("R11 new change used", n, 40);

    // R12 frozen while disabled
    set_ctl(3, 32'h1); set_ctl(1, 32'd60);
    unlock_ctl(0); wr(1, 32'h1);
    set_ctl(2, 32'h0);
    quiet(100, seen); chk("R12 quiet off", 32'(seen), 0);
    set_ctl(2, 32'h1); t0 = cyc; wait_rst(t0, n);
    chk("R12 resume", 32'(n > 0 && n < 60), 1);

    // R8 enabling does not reload
    set_ctl(2, 32'h0); set_ctl(2, 32'h1);
    quiet(200, seen); chk("R8 no reload on enable", 32'(seen), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule